// File: doc/BRIEF.md
# Page Write Load and Program Controller

This block gathers single-byte writes into a one-page staging buffer and then commits them to a synchronous byte-wide storage array. The first accepted write opens a load window and fixes the page. Later writes to the same page refresh the window, and they may arrive in any order or hit the same byte more than once. A per-byte mark records which offsets were loaded. When no byte has been accepted for a set number of clocks, the window closes and a timed programming phase begins. During that phase only the marked offsets of the latched page are copied into the array.

The host sees `busy` for the whole programming phase and a one-clock `cycle_done` when it ends. After that pulse a new load may start. A write aimed at a different page during a load is dropped and sets a sticky `page_err`. A synchronous read port returns array contents with one clock of latency.

The load window length, the programming length and the array address width are parameters. The page size is fixed by the offset width: 6 bits give 64 bytes. With 13 address bits the array holds 8K bytes. The default uses 11 bits to keep elaboration small.

Top module: `page_loader`

## Requirements
- R1: While `rst_n` is low and right after it rises, `busy`, `cycle_done` and `page_err` are 0.
- R2: `wr_addr[5:0]` is the byte offset within a page and `wr_addr[ADDR_W-1:6]` is the page number. The write accepted while idle fixes the page for the whole load. After programming, every loaded byte reads back at its full address.
- R3: A byte is accepted if its write strobe falls on a clock edge fewer than `LOAD_CYC` edges after the previous accepted byte. Exactly `LOAD_CYC` edges after the last accepted byte, the window closes and `busy` is 1. A write on that closing edge is not loaded.
- R4: Bytes of one load may arrive in any offset order. When one offset is written several times in a load, the last value is programmed.
- R5: Only offsets loaded during the window are changed in the array. Every other byte of the page keeps its earlier content.
- R6: `busy` stays 1 for exactly `PROG_CYC` clock cycles per programming phase.
- R7: `cycle_done` is 1 for exactly one cycle, the first cycle in which `busy` is 0 again after programming.
- R8: Writes presented while `busy` is 1 change neither the array nor `page_err`.
- R9: During a load, a write whose page number differs from the latched page is not stored. It does not restart the window and sets `page_err`, which stays 1 until reset.
- R10: A read with `rd_en` high returns `mem[rd_addr]` on `rd_data` one clock later. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | qualified byte write strobe |
| wr_addr | input | ADDR_W | write address: page number above, byte offset in bits 5:0 |
| wr_data | input | 8 | write byte |
| rd_en | input | 1 | read strobe |
| rd_addr | input | ADDR_W | read address |
| rd_data | output | 8 | read byte, one cycle after `rd_en` |
| busy | output | 1 | programming phase in progress |
| cycle_done | output | 1 | one-cycle pulse at the end of programming |
| page_err | output | 1 | sticky flag for a write to a foreign page during a load |

## Verification
The bench builds the block with an 8-clock load window, an 80-clock programming phase and 11 address bits. With these values the window boundary can be hit on the exact closing edge and one edge before it. The whole programming phase can be counted clock by clock. Several complete load-and-program rounds on one page then fit in a short run, which makes it possible to check overwrites, untouched bytes and writes dropped while `busy` against a bench model.

// File: rtl/page_loader.sv
module page_loader #(
  parameter int ADDR_W   = 11,
  parameter int OFS_W    = 6,
  parameter int DATA_W   = 8,
  parameter int LOAD_CYC = 10000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              cycle_done,
  output logic              page_err
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LTW   = $clog2(LOAD_CYC + 1);
  localparam int PCW   = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                   st;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] mask;
  logic [LTW-1:0]        tmr;
  logic [PCW-1:0]        pcnt;
  logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
  logic [DATA_W-1:0]     mem  [DEPTH];

  logic [PG_W-1:0]  wr_page;
  logic [OFS_W-1:0] wr_ofs;
  logic [OFS_W-1:0] p_ofs;
  logic expire, same_pg, accept, prog_wr;

  assign wr_page = wr_addr[ADDR_W-1:OFS_W];
  assign wr_ofs  = wr_addr[OFS_W-1:0];
  assign p_ofs   = pcnt[OFS_W-1:0];
  assign expire  = (st == S_LOAD) && (tmr == LTW'(LOAD_CYC - 1));
  assign same_pg = (wr_page == page_q);
  assign accept  = wr_en && ((st == S_IDLE) || (st == S_LOAD && !expire && same_pg));
  assign prog_wr = (st == S_PROG) && (pcnt < PCW'(PAGE_BYTES)) && mask[p_ofs];
  assign busy    = (st == S_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      page_q     <= '0;
      mask       <= '0;
      tmr        <= '0;
      pcnt       <= '0;
      cycle_done <= 1'b0;
      page_err   <= 1'b0;
    end else begin
      cycle_done <= 1'b0;
      case (st)
        S_IDLE: if (wr_en) begin
          page_q <= wr_page;
          mask   <= PAGE_BYTES'(1) << wr_ofs;
          tmr    <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: if (expire) begin
          st   <= S_PROG;
          pcnt <= '0;
        end else if (wr_en && same_pg) begin
          mask[wr_ofs] <= 1'b1;
          tmr          <= '0;
        end else begin
          tmr <= tmr + 1'b1;
          if (wr_en) page_err <= 1'b1;
        end
        S_PROG: if (pcnt == PCW'(PROG_CYC - 1)) begin
          st         <= S_IDLE;
          cycle_done <= 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (accept) pbuf[wr_ofs] <= wr_data;

  always_ff @(posedge clk)
    if (prog_wr) mem[{page_q, p_ofs}] <= pbuf[p_ofs];

  always_ff @(posedge clk)
    if (rd_en) rd_data <= mem[rd_addr];

  initial assert (PROG_CYC > PAGE_BYTES && LOAD_CYC >= 2 && ADDR_W > OFS_W)
    else $error("page_loader: parameter set not supported");

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);
  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cycle_done);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  assert_foreign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !expire && wr_en && !same_pg) |=> page_err);
  assert_prog_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(mask) && $stable(page_q)));
  assert_load_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !expire) |=> !busy);
endmodule

// File: tb/test_page_loader.sv
module test_page_loader;
  localparam int AW = 11;
  localparam int LC = 8;
  localparam int PC = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, cycle_done, page_err;

  page_loader #(.ADDR_W(AW), .OFS_W(6), .DATA_W(8), .LOAD_CYC(LC), .PROG_CYC(PC)) i_page_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .cycle_done(cycle_done), .page_err(page_err));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [7:0] model [64];

  localparam int NV = 8;
  localparam int VOFS [NV] = '{40, 5, 63, 0, 5, 17, 40, 5};
  localparam int VDAT [NV] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h07, 8'h18};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input int pg, input int ofs, input int d);
    wr_en = 1'b1; wr_addr = AW'((pg << 6) | ofs); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int pg, input int ofs, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = AW'((pg << 6) | ofs);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_done();
    while (!cycle_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    check(busy == 0 && cycle_done == 0 && page_err == 0, "R1 reset", {busy, cycle_done, page_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && cycle_done == 0 && page_err == 0, "R1 after reset", {busy, cycle_done, page_err}, 0);

    // full page fill, then window and programming length
    for (int i = 0; i < 64; i++) begin
      model[i] = 8'(i * 3 + 1);
      wr(3, i, i * 3 + 1);
    end
    repeat (LC - 1) @(negedge clk);
    check(busy == 0, "R3 window still open", busy, 0);
    @(negedge clk);
    check(busy == 1, "R3 window closed", busy, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == PC, "R6 busy length", n, PC);
    check(cycle_done == 1, "R7 done pulse", cycle_done, 1);
    @(negedge clk);
    check(cycle_done == 0, "R7 done single cycle", cycle_done, 0);
    for (int i = 0; i < 64; i++) begin
      rd(3, i, v);
      check(v == model[i], "R2 fill readback", v, model[i]);
    end

    // table-driven partial load, any order with overwrites
    for (int k = 0; k < NV; k++) begin
      model[VOFS[k]] = 8'(VDAT[k]);
      wr(3, VOFS[k], VDAT[k]);
    end
    wait_done();
    rd(3, 5, v);  check(v == 8'h18, "R4 last write wins", v, 8'h18);
    rd(3, 40, v); check(v == 8'h07, "R4 last write wins", v, 8'h07);
    for (int i = 0; i < 64; i++) begin
      rd(3, i, v);
      check(v == model[i], "R5 page contents", v, model[i]);
    end

    // gap at the limit, late byte on the closing edge, write while busy
    wr(3, 1, 8'h11); model[1] = 8'h11;
    repeat (LC - 2) @(negedge clk);
    wr(3, 2, 8'h22); model[2] = 8'h22;
    check(busy == 0, "R3 byte one edge before limit", busy, 0);
    repeat (LC - 1) @(negedge clk);
    wr(3, 3, 8'h33);
    check(busy == 1, "R3 closing edge", busy, 1);
    repeat (5) @(negedge clk);
    wr(3, 4, 8'h44);
    wr(9, 4, 8'h45);
    check(page_err == 0, "R8 no flag while busy", page_err, 0);
    wait_done();
    for (int i = 1; i <= 4; i++) begin
      rd(3, i, v);
      check(v == model[i], (i == 3) ? "R3 late byte dropped" : (i == 4) ? "R8 busy write dropped" : "R3 bytes kept", v, model[i]);
    end

    // foreign page write during a load
    wr(6, 7, 8'h5A);
    wr(3, 10, 8'hEE);
    check(page_err == 1, "R9 flag set", page_err, 1);
    repeat (LC - 2) @(negedge clk);
    check(busy == 0, "R9 window from first byte", busy, 0);
    @(negedge clk);
    check(busy == 1, "R9 window not restarted", busy, 1);
    wait_done();
    rd(3, 10, v); check(v == model[10], "R9 foreign byte not stored", v, model[10]);
    rd(6, 7, v);  check(v == 8'h5A, "R2 other page byte", v, 8'h5A);
    check(page_err == 1, "R9 flag sticky", page_err, 1);

    // read hold
    rd(3, 63, v);
    rd_addr = AW'((3 << 6) | 0);
    repeat (2) @(negedge clk);
    check(rd_data == model[63], "R10 hold without rd_en", rd_data, model[63]);
    rd(3, 0, v); check(v == model[0], "R10 read latency", v, model[0]);

    finish_run();
  end
endmodule